// File: doc/BRIEF.md
# Parallel Port Control-Line Handshake Logic

This block runs the four control lines that sit beside two 8-bit parallel ports. Each port has one line that is always an input and one line that can be an input or an output. A single 8-bit control register holds a 4-bit field per port. Each field picks the active edge of the input-only line. It also picks whether the second line is an input, with its own active edge and an optional independent-interrupt behaviour, or an output driven in handshake, one-cycle pulse, forced-low or forced-high mode.

Every input line passes through a two-flop synchronizer, and the edge selected in the field is turned into a one-cycle set pulse for the interrupt unit. The block also watches the register bus for accesses to the port data registers. The data registers themselves live elsewhere. An access raises sticky clear requests for the port's flags, and each request stays up until the interrupt unit acknowledges it. The same access drives the handshake and pulse behaviour of the output line. A separate alias offset reaches port A's data with none of these side effects.

Top module: `pport_ctl_lines`

## Requirements
- R1: After a synchronous reset the control register reads 0x00, both output enables are 0, both output lines are high, and no set pulse or clear request is active. While a line's direction bit is 0, its output sits high.
- R2: A write at offset 12 loads the control register, and a read at offset 12 returns it on the read data bus. Port A's field is bits 3:0 and port B's field is bits 7:4. Writes at any other offset leave the register unchanged.
- R3: An edge on the input-only line of port p gives a one-cycle pulse on flag_set bit 2p (A=bit 0, B=bit 2), two clock edges after the input changes. Field bit 0 selects the edge: 0 means falling and 1 means rising. The other edge gives no pulse.
- R4: While field bit 3 is 0, an edge on the bidirectional line gives a one-cycle pulse on flag_set bit 2p+1. Field bit 2 selects the edge: 0 means falling and 1 means rising. While field bit 3 is 1, that line gives no pulse.
- R5: A read or a write at the port's data offset (1 for A, 0 for B) sets clr_req bits 2p and 2p+1 from the next cycle on.
- R6: In independent-interrupt mode (field bit 3 = 0 and bit 1 = 1), a data access sets only clr_req bit 2p and leaves bit 2p+1 alone.
- R7: A clr_req bit stays set until the matching clr_ack bit is high, and then it drops one cycle later.
- R8: A read or a write at offset 15 raises no clear request and does not move the port A output line in handshake or pulse mode.
- R9: With field bit 3 = 1, the output enable is 1. Bits 2:1 = 10 hold the line low and 11 hold it high.
- R10: In handshake mode (bits 3:1 = 100), a data access drives the line low from the next cycle. The line returns high once the input-only line of the same port has shown its active edge.
- R11: In pulse mode (bits 3:1 = 101), a single data access drives the line low for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Control register on a read at offset 12, otherwise 0 |
| ctl1_in | input | 2 | Input-only lines, bit 0 port A, bit 1 port B |
| ctl2_in | input | 2 | Bidirectional lines as seen at the pad |
| ctl2_out | output | 2 | Bidirectional line output level |
| ctl2_oe | output | 2 | Bidirectional line output enable |
| flag_set | output | 4 | One-cycle edge pulses {B2,B1,A2,A1} |
| clr_req | output | 4 | Sticky flag-clear requests {B2,B1,A2,A1} |
| clr_ack | input | 4 | Acknowledge that drops the matching clr_req |

## Verification
If the handshake or pulse state is wrong inside the block, the output line shows it one cycle after a data access. The line either fails to drop or stays low too long. A wrong synchronizer or polarity state shows as a missing, doubled or wrong-edge pulse on flag_set within three clock edges of the input change. A wrong clear-request state shows on clr_req in the cycle after the access or the acknowledge, and it stays visible until it is acknowledged. The bench watches each of these windows cycle by cycle.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int NPORT  = 2;
    localparam int FLD_W  = DATA_W / NPORT;
    localparam int NFLAG  = 2 * NPORT;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] OFF_DATA_B = 4'd0;
    localparam logic [ADDR_W-1:0] OFF_DATA_A = 4'd1;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 4'd12;
    localparam logic [ADDR_W-1:0] OFF_A_QUIET = 4'd15;

    typedef enum logic [1:0] {
        OM_HSHAKE = 2'b00,
        OM_PULSE  = 2'b01,
        OM_LOW    = 2'b10,
        OM_HIGH   = 2'b11
    } omode_e;

    typedef struct packed {
        logic       dir_out;
        logic [1:0] sel;
        logic       c1_rise;
    } fld_t;

    function automatic logic fld_indep(input fld_t f);
        return !f.dir_out && f.sel[0];
    endfunction

    function automatic logic fld_c2_rise(input fld_t f);
        return f.sel[1];
    endfunction

    function automatic logic [ADDR_W-1:0] data_off(input int p);
        return (p == 0) ? OFF_DATA_A : OFF_DATA_B;
    endfunction
endpackage

// File: rtl/pport_sync_edge.sv
module pport_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic rise_sel,
    input  logic en,
    output logic set_o
);
    logic [STAGES:0] sh;
    logic synced, prev;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign synced = sh[STAGES-1];
    assign prev   = sh[STAGES];
    assign set_o  = en && (rise_sel ? (synced && !prev) : (!synced && prev));

    // R3/R4: one edge yields a single-cycle pulse
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        set_o |=> (!set_o || (rise_sel != $past(rise_sel))));
endmodule

// File: rtl/pport_line_ctl.sv
module pport_line_ctl
    import pport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dir_out,
    input  logic [1:0] sel,
    input  logic       acc,
    input  logic       c1_set,
    input  logic [1:0] ack,
    output logic       out,
    output logic       oe,
    output logic [1:0] clr_req
);
    omode_e mode;
    logic   hs_q, pls_q, indep, hsm, is_pulse;

    assign mode     = omode_e'(sel);
    assign indep    = !dir_out && sel[0];
    assign hsm      = dir_out && (mode == OM_HSHAKE);
    assign is_pulse = dir_out && (mode == OM_PULSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q  <= 1'b1;
            pls_q <= 1'b0;
        end else begin
            if (!hsm)        hs_q <= 1'b1;
            else if (acc)    hs_q <= 1'b0;
            else if (c1_set) hs_q <= 1'b1;
            pls_q <= acc && is_pulse;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_req <= '0;
        end else begin
            clr_req[0] <= (clr_req[0] && !ack[0]) || acc;
            clr_req[1] <= (clr_req[1] && !ack[1]) || (acc && !indep);
        end
    end

    always_comb begin
        if (!dir_out) begin
            out = 1'b1;
        end else begin
            case (mode)
                OM_HSHAKE: out = hs_q;
                OM_PULSE:  out = !pls_q;
                OM_LOW:    out = 1'b0;
                default:   out = 1'b1;
            endcase
        end
    end
    assign oe = dir_out;

    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !oe |-> out);
    p_pulse_short_r11: assert property (@(posedge clk) disable iff (rst)
        (is_pulse && !acc) |=> (out || !is_pulse));
    p_hs_low_r10: assert property (@(posedge clk) disable iff (rst)
        (hsm && acc) |=> (!out || !hsm));
    p_indep_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && indep && !clr_req[1]) |=> !clr_req[1]);
    p_hold_a_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_req[0] && !ack[0]) |=> clr_req[0]);
    p_hold_b_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_req[1] && !ack[1]) |=> clr_req[1]);
endmodule

// File: rtl/pport_ctl_lines.sv
module pport_ctl_lines
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPORT-1:0]  ctl1_in,
    input  logic [NPORT-1:0]  ctl2_in,
    output logic [NPORT-1:0]  ctl2_out,
    output logic [NPORT-1:0]  ctl2_oe,
    output logic [NFLAG-1:0]  flag_set,
    output logic [NFLAG-1:0]  clr_req,
    input  logic [NFLAG-1:0]  clr_ack
);
    logic [DATA_W-1:0] ctrl_q;
    logic              strobe;

    assign strobe = bus_rd || bus_wr;

    always_ff @(posedge clk) begin
        if (rst)                                ctrl_q <= '0;
        else if (bus_wr && bus_addr == OFF_CTRL) ctrl_q <= bus_wdata;
    end

    assign bus_rdata = (bus_rd && bus_addr == OFF_CTRL) ? ctrl_q : '0;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        fld_t f;
        logic acc;
        assign f   = fld_t'(ctrl_q[p*FLD_W +: FLD_W]);
        assign acc = strobe && (bus_addr == data_off(p));

        pport_sync_edge #(.STAGES(SYNC_STAGES)) u_c1 (
            .clk(clk), .rst(rst), .din(ctl1_in[p]),
            .rise_sel(f.c1_rise), .en(1'b1), .set_o(flag_set[2*p]));

        pport_sync_edge #(.STAGES(SYNC_STAGES)) u_c2 (
            .clk(clk), .rst(rst), .din(ctl2_in[p]),
            .rise_sel(fld_c2_rise(f)), .en(!f.dir_out), .set_o(flag_set[2*p+1]));

        pport_line_ctl u_line (
            .clk(clk), .rst(rst), .dir_out(f.dir_out), .sel(f.sel),
            .acc(acc), .c1_set(flag_set[2*p]), .ack(clr_ack[2*p +: 2]),
            .out(ctl2_out[p]), .oe(ctl2_oe[p]), .clr_req(clr_req[2*p +: 2]));
    end

    p_ctrl_load_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_CTRL) |=> (ctrl_q == $past(bus_wdata)));
    p_quiet_noclr_r8: assert property (@(posedge clk) disable iff (rst)
        (strobe && bus_addr == OFF_A_QUIET && clr_req == '0) |=> (clr_req == '0));
    p_out_dir_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl2_oe[0] && $stable(ctl2_oe[0])) |-> !flag_set[1]);
endmodule

// File: tb/sim_pport_ctl_lines.sv
module sim_pport_ctl_lines;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] ctl1_in = 2'b11, ctl2_in = 2'b11;
    logic [1:0] ctl2_out, ctl2_oe;
    logic [3:0] flag_set, clr_req;
    logic [3:0] clr_ack = '0;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pport_ctl_lines u0 (.*);

    // {ctrl, expected oe, expected out}
    localparam logic [11:0] VEC [6] = '{
        {8'h00, 2'b00, 2'b11}, {8'h0C, 2'b01, 2'b10}, {8'h0E, 2'b01, 2'b11},
        {8'hC0, 2'b10, 2'b01}, {8'hCE, 2'b11, 2'b01}, {8'h88, 2'b11, 2'b11}};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [3:0] a, input logic wr, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = !wr; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_addr = 4'd2;
    endtask

    task automatic read_ctrl(output logic [7:0] v);
        @(negedge clk);
        bus_addr = 4'd12; bus_rd = 1; #1 v = bus_rdata;
        bus_rd = 0; bus_addr = 4'd2;
    endtask

    task automatic ack(input logic [3:0] m);
        @(negedge clk); clr_ack = m;
        @(negedge clk); clr_ack = '0;
    endtask

    task automatic count_set(input int idx, output int n);
        n = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            n += int'(flag_set[idx]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        read_ctrl(v); chk("R1 ctrl", v, 0);
        chk("R1 oe", ctl2_oe, 0); chk("R1 out", ctl2_out, 3);
        chk("R1 clr", clr_req, 0); chk("R1 set", flag_set, 0);

        // R2 and R9 table walk
        for (int i = 0; i < 6; i++) begin
            access(4'd12, 1, VEC[i][11:4]);
            read_ctrl(v); chk("R2 readback", v, VEC[i][11:4]);
            chk("R9 oe", ctl2_oe, VEC[i][3:2]);
            chk("R9 out", ctl2_out, VEC[i][1:0]);
        end
        access(4'd11, 1, 8'h55);
        read_ctrl(v); chk("R2 other offset", v, 8'h88);

        // R3 input-only edges
        access(4'd12, 1, 8'h00);
        @(negedge clk); ctl1_in[0] = 0; count_set(0, n); chk("R3 A fall", n, 1);
        @(negedge clk); ctl1_in[0] = 1; count_set(0, n); chk("R3 A rise ignored", n, 0);
        access(4'd12, 1, 8'h10);
        @(negedge clk); ctl1_in[1] = 0; count_set(2, n); chk("R3 B fall ignored", n, 0);
        @(negedge clk); ctl1_in[1] = 1; count_set(2, n); chk("R3 B rise", n, 1);

        // R4 bidirectional line as input
        access(4'd12, 1, 8'h00);
        @(negedge clk); ctl2_in[0] = 0; count_set(1, n); chk("R4 A fall", n, 1);
        access(4'd12, 1, 8'h04);
        @(negedge clk); ctl2_in[0] = 1; count_set(1, n); chk("R4 A rise", n, 1);
        access(4'd12, 1, 8'h08);
        @(negedge clk); ctl2_in[0] = 0; count_set(1, n); chk("R4 output no pulse", n, 0);
        @(negedge clk); ctl2_in[0] = 1; count_set(1, n); chk("R4 output no pulse", n, 0);

        // R5 / R7 clear requests
        access(4'd12, 1, 8'h00);
        ack(4'hF);
        chk("R7 cleared", clr_req, 0);
        access(4'd1, 0, 0); chk("R5 A read", clr_req, 4'b0011);
        ack(4'b0001); chk("R7 partial ack", clr_req, 4'b0010);
        repeat (3) @(negedge clk); chk("R7 held", clr_req, 4'b0010);
        access(4'd0, 1, 8'hAA); chk("R5 B write", clr_req, 4'b1110);
        ack(4'hF); chk("R7 all ack", clr_req, 0);

        // R6 independent interrupt
        access(4'd12, 1, 8'h02);
        access(4'd1, 1, 8'h01); chk("R6 indep", clr_req, 4'b0001);
        ack(4'hF);

        // R8 quiet alias
        access(4'd12, 1, 8'h0A);
        access(4'd15, 1, 8'h33); chk("R8 no clr", clr_req, 0); chk("R8 no pulse", ctl2_out[0], 1);
        @(negedge clk); chk("R8 no pulse later", ctl2_out[0], 1);
        access(4'd15, 0, 0); chk("R8 read no clr", clr_req, 0);

        // R11 pulse
        access(4'd1, 1, 8'h01); chk("R11 low", ctl2_out[0], 0);
        @(negedge clk); chk("R11 back high", ctl2_out[0], 1);
        ack(4'hF);

        // R10 handshake port A (falling c1 edge)
        access(4'd12, 1, 8'h08);
        chk("R10 idle", ctl2_out[0], 1);
        access(4'd1, 0, 0); chk("R10 A low", ctl2_out[0], 0);
        repeat (4) @(negedge clk); chk("R10 A holds", ctl2_out[0], 0);
        @(negedge clk); ctl1_in[0] = 0;
        repeat (5) @(negedge clk); chk("R10 A released", ctl2_out[0], 1);

        // R10 handshake port B (rising c1 edge)
        access(4'd12, 1, 8'h90);
        @(negedge clk); ctl1_in[1] = 0;
        repeat (5) @(negedge clk);
        access(4'd0, 1, 8'h00); chk("R10 B low", ctl2_out[1], 0);
        repeat (3) @(negedge clk); chk("R10 B holds", ctl2_out[1], 0);
        @(negedge clk); ctl1_in[1] = 1;
        repeat (5) @(negedge clk); chk("R10 B released", ctl2_out[1], 1);

        finish_run();
    end
endmodule